// File: doc/BRIEF.md
# Staged Output Sequencer on a Shared Elapsed-Time Count

This block brings four output lines on one after another from a single accumulated seconds count, instead of chaining one timer per stage. A level input holds the sequence in the running state; while it is high, every clock edge that also sees the prescaled tick-enable high adds one second to the count. Greater-or-equal comparators against that one count decide when the middle stages come on, and the last stage comes on when the count reaches its preset, where the count then stops.

Dropping the run level clears the count and turns every output off at the next clock, whatever the tick input does in that cycle. Because the comparisons are greater-or-equal, a stage that has come on stays on for the rest of the run. The outputs and the count are registered together, so the count seen on the port always matches the stage pattern beside it.

Top module: `staged_sequencer`

## Requirements
- R1: While `rst_n` is low, and after its release until the run level is sampled high, `stage_on` is 4'b0000 and `elapsed` is 0.
- R2: `stage_on[0]` (output 1) is high from the first clock edge at which `run_lvl` is sampled high, whether or not `tick_en` is high.
- R3: With `run_lvl` high and `elapsed` below the preset, `elapsed` rises by exactly one at each edge where `tick_en` is high and holds its value at each edge where `tick_en` is low.
- R4: While running, `stage_on[1]` (output 2) is high exactly when `elapsed` is 5 or more.
- R5: While running, `stage_on[2]` (output 3) is high exactly when `elapsed` is 15 or more.
- R6: While running, `stage_on[3]` (output 4) is high exactly when `elapsed` has reached the 25-second preset.
- R7: `elapsed` never exceeds 25; further ticks at 25 leave it at 25 and all four outputs high.
- R8: An edge with `run_lvl` sampled low sets `elapsed` to 0 and `stage_on` to 4'b0000 at that edge, even if `tick_en` is high; a new run then starts again from 0.
- R9: A higher stage is never on while a lower one is off (`stage_on` is always of the form 0...01...1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| tick_en | input | 1 | One-second prescaled tick, one clock wide per second |
| run_lvl | input | 1 | Run/stop level: high runs the sequence, low clears it |
| stage_on | output | 4 | Stage outputs; bit 0 is output 1, bit 3 is output 4 |
| elapsed | output | 5 | Accumulated seconds since the run began |

## Verification
The two functions that can land on one edge are the count step and the clear: a tick arriving in the very cycle the run level drops. The bench provokes this with the count sitting one below the 5-second threshold and again at the saturated preset, each time with the tick held high while the level falls, and judges that the edge yields a zero count and all outputs off rather than a crossed threshold. The same collision of tick and saturation is judged by ticking at 25 and expecting the count and outputs unchanged.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int unsigned NUM_STAGES = 4;
  typedef logic [NUM_STAGES-1:0] stage_vec_t;
endpackage

// File: rtl/seq_elapsed_cnt.sv
module seq_elapsed_cnt #(
  parameter int unsigned PRESET = 25,
  localparam int unsigned CNT_W = $clog2(PRESET + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_lvl,
  input  logic             tick_en,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             done_nxt
);
  localparam logic [CNT_W-1:0] PRESET_V = CNT_W'(PRESET);

  logic at_top;
  logic step_en;

  assign at_top  = (cnt_q == PRESET_V);
  assign step_en = run_lvl & tick_en & ~at_top;

  always_comb begin
    if (!run_lvl) begin
      cnt_nxt = '0;
    end else if (step_en) begin
      cnt_nxt = cnt_q + CNT_W'(1);
    end else begin
      cnt_nxt = cnt_q;
    end
  end

  assign done_nxt = run_lvl & (cnt_nxt == PRESET_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_nxt;
    end
  end

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= PRESET_V);

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run_lvl && tick_en && cnt_q != PRESET_V) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run_lvl && !tick_en) |=> $stable(cnt_q));

  a_r8_clear_cnt: assert property (@(posedge clk) disable iff (!rst_n)
    !run_lvl |=> (cnt_q == '0));
endmodule

// File: rtl/seq_stage_cmp.sv
module seq_stage_cmp #(
  parameter int unsigned CNT_W  = 5,
  parameter int unsigned THRESH = 5
) (
  input  logic [CNT_W-1:0] cnt,
  output logic             hit
);
  localparam logic [CNT_W-1:0] TH_V = CNT_W'(THRESH);
  assign hit = (cnt >= TH_V);
endmodule

// File: rtl/seq_out_reg.sv
module seq_out_reg
  import seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_lvl,
  input  stage_vec_t stage_nxt,
  output stage_vec_t stage_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_nxt;
    end
  end

  a_r2_first_on: assert property (@(posedge clk) disable iff (!rst_n)
    run_lvl |=> stage_q[0]);

  a_r8_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    !run_lvl |=> (stage_q == '0));

  a_r9_order: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q & (stage_q + stage_vec_t'(1))) == '0);
endmodule

// File: rtl/staged_sequencer.sv
module staged_sequencer
  import seq_pkg::*;
#(
  parameter int unsigned TH_SECOND = 5,
  parameter int unsigned TH_THIRD  = 15,
  parameter int unsigned PRESET    = 25,
  localparam int unsigned CNT_W    = $clog2(PRESET + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick_en,
  input  logic                        run_lvl,
  output logic [NUM_STAGES-1:0]       stage_on,
  output logic [CNT_W-1:0]            elapsed
);
  logic [CNT_W-1:0] cnt_nxt;
  logic             done_nxt;
  stage_vec_t       stage_nxt;
  stage_vec_t       stage_q;

  seq_elapsed_cnt #(.PRESET(PRESET)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_lvl  (run_lvl),
    .tick_en  (tick_en),
    .cnt_q    (elapsed),
    .cnt_nxt  (cnt_nxt),
    .done_nxt (done_nxt)
  );

  assign stage_nxt[0] = run_lvl;

  for (genvar gi = 1; gi < NUM_STAGES - 1; gi++) begin : g_cmp
    localparam int unsigned TH = (gi == 1) ? TH_SECOND : TH_THIRD;
    logic hit;
    seq_stage_cmp #(.CNT_W(CNT_W), .THRESH(TH)) u_cmp (
      .cnt (cnt_nxt),
      .hit (hit)
    );
    assign stage_nxt[gi] = run_lvl & hit;
  end

  assign stage_nxt[NUM_STAGES-1] = done_nxt;

  seq_out_reg u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_lvl   (run_lvl),
    .stage_nxt (stage_nxt),
    .stage_q   (stage_q)
  );

  assign stage_on = stage_q;

  a_r4_second: assert property (@(posedge clk) disable iff (!rst_n)
    stage_q[0] |-> (stage_q[1] == (elapsed >= CNT_W'(TH_SECOND))));

  a_r6_last: assert property (@(posedge clk) disable iff (!rst_n)
    stage_q[0] |-> (stage_q[3] == (elapsed == CNT_W'(PRESET))));
endmodule

// File: tb/staged_sequencer_bench.sv
module staged_sequencer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       run_lvl = 1'b0;
  logic [3:0] stage_on;
  logic [4:0] elapsed;

  int n_tests = 0;
  int n_fail  = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  staged_sequencer u_staged_sequencer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .run_lvl  (run_lvl),
    .stage_on (stage_on),
    .elapsed  (elapsed)
  );

  localparam int NV = 12;
  localparam int V_RUN [NV]  = '{1, 1, 1, 1, 1, 1, 1, 1, 1, 0, 0, 1};
  localparam int V_TICK[NV]  = '{0, 1, 0, 1, 1, 1, 1, 1, 1, 1, 1, 1};
  localparam int V_REPS[NV]  = '{1, 4, 3, 1, 9, 1, 9, 1, 5, 1, 3, 1};
  localparam int V_CNT [NV]  = '{0, 4, 4, 5, 14, 15, 24, 25, 25, 0, 0, 1};
  localparam int V_STG [NV]  = '{1, 1, 1, 3, 3, 7, 7, 15, 15, 0, 0, 1};
  localparam string V_REQ[NV] = '{"R2", "R3", "R3", "R4", "R4", "R5", "R5", "R6", "R7", "R8", "R8", "R8"};

  function automatic bit ordered(input logic [3:0] s);
    return (s == 4'b0000) || (s == 4'b0001) || (s == 4'b0011) ||
           (s == 4'b0111) || (s == 4'b1111);
  endfunction

  task automatic check(input string req, input int exp_cnt, input int exp_stg);
    n_tests++;
    if (elapsed !== 5'(exp_cnt) || stage_on !== 4'(exp_stg)) begin
      n_fail++;
      $display("FAIL %s: elapsed=%0d stage_on=%b expected elapsed=%0d stage_on=%b",
               req, elapsed, stage_on, exp_cnt, 4'(exp_stg));
    end
    n_tests++;
    if (!ordered(stage_on)) begin
      n_fail++;
      $display("FAIL R9: stage_on=%b expected a contiguous pattern from bit 0", stage_on);
    end
  endtask

  task automatic step(input logic r, input logic t);
    @(negedge clk);
    run_lvl = r;
    tick_en = t;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #100000;
    if (!done_flag) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state, then idle after release
    #9;
    check("R1", 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b1);
    check("R1", 0, 0);

    for (int v = 0; v < NV; v++) begin
      for (int k = 0; k < V_REPS[v]; k++) begin
        step(V_RUN[v] != 0, V_TICK[v] != 0);
      end
      check(V_REQ[v], V_CNT[v], V_STG[v]);
    end

    // R8: drop the level on a tick edge with the count one below 5
    step(1'b0, 1'b0);
    for (int k = 0; k < 4; k++) step(1'b1, 1'b1);
    check("R3", 4, 1);
    step(1'b0, 1'b1);
    check("R8", 0, 0);

    // R8: drop the level on a tick edge at the saturated preset
    for (int k = 0; k < 30; k++) step(1'b1, 1'b1);
    check("R7", 25, 15);
    step(1'b0, 1'b1);
    check("R8", 0, 0);

    // R2: first run edge with the tick low still turns output 1 on
    step(1'b1, 1'b0);
    check("R2", 0, 1);

    // R1: asynchronous reset mid-run
    for (int k = 0; k < 16; k++) step(1'b1, 1'b1);
    check("R5", 16, 7);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", 0, 0);
    @(negedge clk);
    run_lvl = 1'b0;
    rst_n = 1'b1;
    step(1'b0, 1'b0);
    check("R1", 0, 0);

    done_flag = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule